// File: doc/BRIEF.md
# Interrupt and Exception Vector Selector

This block sits beside the instruction sequencer and decides, cycle by cycle, whether control must divert into an interrupt service sequence. Two internal exceptions are taken at once: a divide fault and an undefined opcode. The undefined opcode is detected from the opcode byte and, for the 0xFF group, from the reg field of the ModRM byte. Three further sources are only weighed when the sequencer signals an instruction boundary: a non-maskable request, a maskable request that carries an 8-bit number, and the single-step trap.

When a source wins, the block raises a one-cycle take strobe. With that strobe it gives the byte offset of the chosen entry in the vector table and the microcode address at which the service sequence starts. The internal sources use fixed offsets. An external request uses its number multiplied by four. All outputs are registered, so they appear one clock after the inputs that caused them.

Top module: `intvec_sel`

## Requirements
- R1: While reset is low, and in the first cycle after it, `take_int` is 0 and `vec_offset` and `entry_addr` are zero.
- R2: A `div_fault` sampled high is taken on the next cycle with offset 0x0000 and entry 0x101, whether or not a boundary is present. It has the highest priority.
- R3: With `op_valid` high, the opcodes 0x0F, 0x63, 0x64, 0x65, 0x66, 0x67 and 0xF1 are undefined. Opcode 0xFF is also undefined when `modrm_reg` is 7. An undefined opcode is taken without a boundary, with offset 0x0018 and entry 0x130, unless `div_fault` is high in the same cycle. Other opcodes, or any opcode with `op_valid` low, raise nothing.
- R4: A pending non-maskable request is taken at a boundary with no exception present, with offset 0x0008 and entry 0x12A. It outranks the maskable request and the trap.
- R5: The non-maskable line is latched on its rising edge. A line held high is serviced once. A request stays pending across cycles with no boundary, and across cycles where an exception wins.
- R6: A maskable request with `int_en` high is taken at a boundary when no exception and no non-maskable request are pending. Its offset is `irq_num` × 4 and its entry is 0x12B.
- R7: A maskable request with `int_en` low is ignored.
- R8: With `trap_en` high, a boundary with nothing of higher rank is taken with offset 0x0004 and entry 0x12C.
- R9: Non-maskable, maskable and trap sources are never taken in a cycle with `insn_end` low.
- R10: `take_int` lasts one cycle per decision. When it is low, `vec_offset` and `entry_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_fault | input | 1 | Divide fault pulse |
| op_valid | input | 1 | Opcode and reg field are valid this cycle |
| opcode | input | 8 | Current opcode byte |
| modrm_reg | input | 3 | Reg field of the ModRM byte |
| insn_end | input | 1 | Instruction boundary |
| nmi_line | input | 1 | Non-maskable request line, edge sensitive |
| irq_req | input | 1 | Maskable request, level |
| irq_num | input | 8 | Number of the maskable request |
| int_en | input | 1 | Interrupt-enable flag |
| trap_en | input | 1 | Single-step trap flag |
| take_int | output | 1 | Take-interrupt strobe |
| vec_offset | output | 16 | Vector table byte offset |
| entry_addr | output | 9 | Microcode entry address |

## Verification
The hardest case to reach is a latched non-maskable request that must survive. It is held over cycles with no boundary, and over a boundary where an exception takes priority. A second rising edge can also arrive in the same cycle the request is taken. Random stimulus covers these overlaps: the line toggles often, boundaries are sparse, and exceptions are common. Directed sequences add a long-held line and a fault at a boundary with a request pending. The bench keeps its own model of the pending bit.

// File: rtl/intvec_pkg.sv
// Shared types for the vector selector: the cause that wins a cycle.
package intvec_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_DIV   = 3'd1,
        CAUSE_INVOP = 3'd2,
        CAUSE_NMI   = 3'd3,
        CAUSE_IRQ   = 3'd4,
        CAUSE_TRAP  = 3'd5
    } cause_e;

    localparam int NUM_SRC = 5;
endpackage

// File: rtl/intvec_opcheck.sv
// Flags undefined opcodes. The listed single opcodes are undefined
// outright. The group opcode is undefined only with one reg value.
// Assumes opcode and reg are stable while op_valid is high.
module intvec_opcheck #(
    parameter int OPC_W     = 8,
    parameter int REG_W     = 3,
    parameter int N_BAD     = 7,
    parameter logic [OPC_W-1:0] GROUP_OPC = 8'hFF,
    parameter logic [REG_W-1:0] GROUP_REG = 3'd7
) (
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [REG_W-1:0] modrm_reg,
    output logic             bad_op
);
    localparam logic [OPC_W-1:0] BAD_LIST [N_BAD] =
        '{8'h0F, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF1};

    logic [N_BAD-1:0] hit;

    // one comparator per listed opcode
    genvar g;
    generate
        for (g = 0; g < N_BAD; g++) begin : g_cmp
            assign hit[g] = (opcode == BAD_LIST[g]);
        end
    endgenerate

    // combine list hits with the group case
    always_comb begin
        bad_op = op_valid &&
                 ((|hit) || (opcode == GROUP_OPC && modrm_reg == GROUP_REG));
    end
endmodule

// File: rtl/intvec_nmi_latch.sv
// Latches the rising edge of the non-maskable line. The bit stays
// pending until the arbiter grants it. A new edge in the grant cycle
// re-arms it. Assumes nmi_line is already synchronous to clk.
module intvec_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_line,
    input  logic taken,
    output logic pend,
    output logic rise
);
    logic line_q;

    // edge of the line against its last sampled value
    always_comb rise = nmi_line && !line_q;

    // sample the line and keep the pending bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            line_q <= nmi_line;
            pend   <= (pend && !taken) || rise;
        end
    end

    AST_NMI_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !rise) |=> !pend); // R5
    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !taken) |=> pend); // R5
endmodule

// File: rtl/intvec_arbiter.sv
// Fixed-priority choice among the five sources. Exceptions win in any
// cycle. Boundary sources are weighed only at a boundary. Purely
// combinational; the clock feeds only the checks.
module intvec_arbiter
    import intvec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   div_fault,
    input  logic   bad_op,
    input  logic   insn_end,
    input  logic   nmi_pend,
    input  logic   irq_req,
    input  logic   int_en,
    input  logic   trap_en,
    output cause_e cause,
    output logic   nmi_taken
);
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] grant;

    // raw requests in rank order, bit 0 highest
    always_comb begin
        req[0] = div_fault;
        req[1] = bad_op;
        req[2] = insn_end && nmi_pend;
        req[3] = insn_end && irq_req && int_en;
        req[4] = insn_end && trap_en;
    end

    // first set bit wins
    always_comb begin
        grant = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && grant == '0) grant[i] = 1'b1;
        end
    end

    // encode the grant
    always_comb begin
        unique case (1'b1)
            grant[0]: cause = CAUSE_DIV;
            grant[1]: cause = CAUSE_INVOP;
            grant[2]: cause = CAUSE_NMI;
            grant[3]: cause = CAUSE_IRQ;
            grant[4]: cause = CAUSE_TRAP;
            default:  cause = CAUSE_NONE;
        endcase
    end

    always_comb nmi_taken = grant[2];

    AST_NO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_end |-> (cause != CAUSE_NMI && cause != CAUSE_IRQ
                       && cause != CAUSE_TRAP)); // R9
    AST_DIV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        div_fault |-> cause == CAUSE_DIV); // R2
endmodule

// File: rtl/intvec_sel.sv
// Top of the vector selector. It registers the winning cause as a
// take strobe with its vector table byte offset and microcode entry.
// Assumes the sequencer acts on take_int in the cycle it is high.
module intvec_sel
    import intvec_pkg::*;
#(
    parameter int OPC_W   = 8,
    parameter int REG_W   = 3,
    parameter int NUM_W   = 8,
    parameter int OFF_W   = 16,
    parameter int ENTRY_W = 9,
    parameter logic [OFF_W-1:0]   OFF_DIV   = 16'h0000,
    parameter logic [OFF_W-1:0]   OFF_TRAP  = 16'h0004,
    parameter logic [OFF_W-1:0]   OFF_NMI   = 16'h0008,
    parameter logic [OFF_W-1:0]   OFF_INVOP = 16'h0018,
    parameter logic [ENTRY_W-1:0] ENT_DIV   = 9'h101,
    parameter logic [ENTRY_W-1:0] ENT_NMI   = 9'h12A,
    parameter logic [ENTRY_W-1:0] ENT_IRQ   = 9'h12B,
    parameter logic [ENTRY_W-1:0] ENT_TRAP  = 9'h12C,
    parameter logic [ENTRY_W-1:0] ENT_INVOP = 9'h130
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_fault,
    input  logic               op_valid,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [REG_W-1:0]   modrm_reg,
    input  logic               insn_end,
    input  logic               nmi_line,
    input  logic               irq_req,
    input  logic [NUM_W-1:0]   irq_num,
    input  logic               int_en,
    input  logic               trap_en,
    output logic               take_int,
    output logic [OFF_W-1:0]   vec_offset,
    output logic [ENTRY_W-1:0] entry_addr
);
    localparam int SCALE_SH = 2;

    logic   bad_op;
    logic   nmi_pend;
    logic   nmi_rise;
    logic   nmi_taken;
    cause_e cause;
    logic [OFF_W-1:0]   off_d;
    logic [ENTRY_W-1:0] ent_d;

    intvec_opcheck #(.OPC_W(OPC_W), .REG_W(REG_W)) opcheck_i (
        .op_valid  (op_valid),
        .opcode    (opcode),
        .modrm_reg (modrm_reg),
        .bad_op    (bad_op)
    );

    intvec_nmi_latch nmi_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_line (nmi_line),
        .taken    (nmi_taken),
        .pend     (nmi_pend),
        .rise     (nmi_rise)
    );

    intvec_arbiter arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_fault (div_fault),
        .bad_op    (bad_op),
        .insn_end  (insn_end),
        .nmi_pend  (nmi_pend),
        .irq_req   (irq_req),
        .int_en    (int_en),
        .trap_en   (trap_en),
        .cause     (cause),
        .nmi_taken (nmi_taken)
    );

    // map the cause to its table offset and entry address
    always_comb begin
        off_d = '0;
        ent_d = '0;
        case (cause)
            CAUSE_DIV:   begin off_d = OFF_DIV;   ent_d = ENT_DIV;   end
            CAUSE_INVOP: begin off_d = OFF_INVOP; ent_d = ENT_INVOP; end
            CAUSE_NMI:   begin off_d = OFF_NMI;   ent_d = ENT_NMI;   end
            CAUSE_IRQ:   begin
                off_d = OFF_W'(irq_num) << SCALE_SH;
                ent_d = ENT_IRQ;
            end
            CAUSE_TRAP:  begin off_d = OFF_TRAP;  ent_d = ENT_TRAP;  end
            default:     begin off_d = '0;        ent_d = '0;        end
        endcase
    end

    // register the decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_int   <= 1'b0;
            vec_offset <= '0;
            entry_addr <= '0;
        end else begin
            take_int   <= (cause != CAUSE_NONE);
            vec_offset <= off_d;
            entry_addr <= ent_d;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_int |-> (vec_offset == '0 && entry_addr == '0)); // R10
    AST_IRQ_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && entry_addr == ENT_IRQ) |->
        (vec_offset == (OFF_W'($past(irq_num)) << SCALE_SH))); // R6
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && entry_addr == ENT_IRQ) |-> $past(int_en)); // R7
    AST_DIV_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(div_fault) |-> (take_int && entry_addr == ENT_DIV
                              && vec_offset == OFF_DIV)); // R2
endmodule

// File: tb/intvec_sel_tb.sv
module intvec_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_fault = 0, op_valid = 0, insn_end = 0, nmi_line = 0;
    logic       irq_req = 0, int_en = 0, trap_en = 0;
    logic [7:0] opcode = 0, irq_num = 0;
    logic [2:0] modrm_reg = 0;
    logic        take_int;
    logic [15:0] vec_offset;
    logic [8:0]  entry_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model state
    bit   m_pend = 0, m_prev = 0;
    bit   e_take = 0;
    logic [15:0] e_off = 0;
    logic [8:0]  e_ent = 0;
    string e_req = "R1";

    always #10 clk = ~clk; // 50 MHz

    intvec_sel dut_i (
        .clk(clk), .rst_n(rst_n), .div_fault(div_fault), .op_valid(op_valid),
        .opcode(opcode), .modrm_reg(modrm_reg), .insn_end(insn_end),
        .nmi_line(nmi_line), .irq_req(irq_req), .irq_num(irq_num),
        .int_en(int_en), .trap_en(trap_en), .take_int(take_int),
        .vec_offset(vec_offset), .entry_addr(entry_addr)
    );

    function automatic bit is_undef(logic v, logic [7:0] op, logic [2:0] r);
        if (!v) return 0;
        case (op)
            8'h0F, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF1: return 1;
            8'hFF: return (r == 3'd7);
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compute expected outputs for the inputs now driven, update model
    task automatic model_step();
        bit rise = nmi_line && !m_prev;
        bit took_nmi = 0;
        e_take = 1; e_off = 0; e_ent = 0;
        if (div_fault) begin
            e_off = 16'h0000; e_ent = 9'h101; e_req = "R2";
        end else if (is_undef(op_valid, opcode, modrm_reg)) begin
            e_off = 16'h0018; e_ent = 9'h130; e_req = "R3";
        end else if (insn_end && m_pend) begin
            e_off = 16'h0008; e_ent = 9'h12A; e_req = "R4"; took_nmi = 1;
        end else if (insn_end && irq_req && int_en) begin
            e_off = {6'b0, irq_num, 2'b00}; e_ent = 9'h12B; e_req = "R6";
        end else if (insn_end && trap_en) begin
            e_off = 16'h0004; e_ent = 9'h12C; e_req = "R8";
        end else begin
            e_take = 0; e_req = "R10";
        end
        m_pend = (m_pend && !took_nmi) || rise;
        m_prev = nmi_line;
    endtask

    // one cycle: check last outputs, then drive and predict
    task automatic cycle_check();
        @(negedge clk);
        check({e_req, " take"}, 32'(take_int), 32'(e_take));
        check({e_req, " offset"}, 32'(vec_offset), 32'(e_off));
        check({e_req, " entry"}, 32'(entry_addr), 32'(e_ent));
    endtask

    task automatic clear_in();
        div_fault = 0; op_valid = 0; insn_end = 0; irq_req = 0;
        int_en = 0; trap_en = 0; opcode = 8'h90; modrm_reg = 0; irq_num = 0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        clear_in();
        repeat (3) @(negedge clk);
        // R1: outputs zero in reset
        check("R1 take in reset", 32'(take_int), 0);
        check("R1 offset in reset", 32'(vec_offset), 0);
        @(negedge clk);
        rst_n = 1;
        model_step();          // idle inputs
        cycle_check();         // R1: first cycle after reset

        // R9: NMI edge without boundary, held line, no take until boundary
        nmi_line = 1; model_step(); cycle_check();
        repeat (3) begin model_step(); cycle_check(); end
        check("R9 no take off boundary", 32'(take_int), 0);
        // R2 beats pending NMI at a boundary; NMI stays pending (R5)
        insn_end = 1; div_fault = 1; model_step(); cycle_check();
        div_fault = 0; model_step(); cycle_check();
        check("R4 nmi after fault", 32'(entry_addr), 32'h12A);
        // R5: held line, more boundaries -> no second NMI
        repeat (4) begin model_step(); cycle_check(); end
        check("R5 held line once", 32'(take_int), 0);
        nmi_line = 0; insn_end = 0;

        // R6: max irq number
        insn_end = 1; irq_req = 1; int_en = 1; irq_num = 8'hFF;
        model_step(); cycle_check();
        check("R6 offset 0x3FC", 32'(vec_offset), 32'h3FC);
        // R7: masked irq ignored, trap takes instead (R8)
        int_en = 0; trap_en = 1; model_step(); cycle_check();
        check("R7 masked irq", 32'(entry_addr), 32'h12C);
        trap_en = 0; model_step(); cycle_check();
        check("R7 masked irq idle", 32'(take_int), 0);
        // R3: group opcode with reg 7 and reg 6
        clear_in(); op_valid = 1; opcode = 8'hFF; modrm_reg = 3'd7;
        model_step(); cycle_check();
        check("R3 group reg7", 32'(vec_offset), 32'h18);
        modrm_reg = 3'd6; model_step(); cycle_check();
        check("R3 group reg6 legal", 32'(take_int), 0);
        clear_in();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            div_fault = ($urandom_range(0, 15) == 0);
            op_valid  = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: opcode = 8'h63 + 8'($urandom_range(0, 4));
                1: opcode = 8'hFF;
                2: opcode = ($urandom_range(0, 1) != 0) ? 8'h0F : 8'hF1;
                default: opcode = 8'($urandom());
            endcase
            modrm_reg = 3'($urandom());
            insn_end  = ($urandom_range(0, 2) == 0);
            nmi_line  = ($urandom_range(0, 3) == 0) ? ~nmi_line : nmi_line;
            irq_req   = $urandom_range(0, 1);
            irq_num   = 8'($urandom());
            int_en    = $urandom_range(0, 1);
            trap_en   = ($urandom_range(0, 3) == 0);
            model_step();
            cycle_check();
        end
        clear_in(); model_step(); cycle_check();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule